// File: doc/BRIEF.md
# Pad function multiplexer with banked GPIO

This block sits between a large array of general-purpose pads and the logic that uses them. Each pad can be given to a built-in GPIO or to one of three peripheral clients. A 2-bit function select per pin makes that choice. The pads are grouped into banks of eight. Each bank has an 8-byte window on a byte-wide register bus. The window holds the select fields, a GPIO driver-enable byte, a GPIO output-level byte and a read-only byte that returns the pad levels.

Software picks a function for each pin by writing its select field. For a GPIO pin, software sets the direction and output level through the bank's driver and level bytes. Software reads pad levels from the sense byte whatever function the pin has. Before it claims a pin as GPIO, software reads the select field and expects zero, so every select field reads back exactly as written. Each client drives its own output and output-enable vectors. Every client receives the raw pad input vector.

Top module: `pinmux_bank_ctrl`

## Requirements
- R1: There are 18 banks of 8 pins, 144 pins in all. Pin number is bank*8 + index. Bank n's window starts at byte address 0x20 + 8*n, and every access moves one byte.
- R2: Window byte +0 holds the selects of pins 0 to 3 and byte +1 holds those of pins 4 to 7. A pin's 2-bit field sits at bit (index mod 4)*2. Both bytes read back exactly what was written.
- R3: Select value 0 means GPIO. For such a pin, pad_out follows its bit in the level byte (+3) and pad_oe follows its bit in the driver byte (+2), where 1 drives and 0 makes the pin an input.
- R4: Select values 1, 2 and 3 connect the pad to client A, B and C. pad_out and pad_oe then come from that client's vectors, and the driver and level bytes have no effect on the pin.
- R5: The driver byte at +2 is readable and writable.
- R6: The level byte at +3 is readable and writable.
- R7: Byte +6 returns the pad levels of the bank through a two-flop synchroniser, whatever function each pin has. Writes to it are ignored.
- R8: Offsets +4, +5 and +7 read zero and ignore writes. Addresses below 0x20 or at and above 0x20 + 8*18 also read zero and ignore writes.
- R9: After reset every select, driver and level bit is zero, so pad_oe and pad_out are all zero.
- R10: A write takes effect on the clock edge where reg_we is high. With RD_REG=1 (the default), reg_rdata is registered and shows the byte addressed one cycle earlier; with RD_REG=0 it is combinational.
- R11: cli_a_in, cli_b_in and cli_c_in all equal pad_in, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Read data |
| pad_in | input | 144 | Pad input levels |
| pad_out | output | 144 | Pad output levels |
| pad_oe | output | 144 | Pad output enables |
| cli_a_out | input | 144 | Client A output levels |
| cli_a_oe | input | 144 | Client A output enables |
| cli_a_in | output | 144 | Pad levels to client A |
| cli_b_out | input | 144 | Client B output levels |
| cli_b_oe | input | 144 | Client B output enables |
| cli_b_in | output | 144 | Pad levels to client B |
| cli_c_out | input | 144 | Client C output levels |
| cli_c_oe | input | 144 | Client C output enables |
| cli_c_in | output | 144 | Pad levels to client C |

## Verification
The hardest case to reach from the ports is one bank with all four functions active at once while the GPIO bytes hold values that would show through if the routing leaked. The bench first programs a GPIO pattern into a bank. It then gives the four upper pins four different selects and drives the three clients with contrasting out and enable vectors. Finally it sets the driver and level bytes to all ones, so that only the one pin still in GPIO mode may change.

// File: rtl/pmx_pkg.sv
package pmx_pkg;

    localparam int          BANKS         = 18;
    localparam int          PINS_PER_BANK = 8;
    localparam int          BANK_IDX_W    = 5;
    localparam logic [7:0]  BANK_BASE     = 8'h20;

    typedef enum logic [1:0] {
        FN_GPIO  = 2'd0,
        FN_CLI_A = 2'd1,
        FN_CLI_B = 2'd2,
        FN_CLI_C = 2'd3
    } pin_fn_e;

    typedef enum logic [2:0] {
        OFS_SEL_LO = 3'd0,
        OFS_SEL_HI = 3'd1,
        OFS_DRIVE  = 3'd2,
        OFS_LEVEL  = 3'd3,
        OFS_RSV4   = 3'd4,
        OFS_RSV5   = 3'd5,
        OFS_SENSE  = 3'd6,
        OFS_RSV7   = 3'd7
    } win_ofs_e;

    typedef struct packed {
        logic [15:0] sel;
        logic [7:0]  drive;
        logic [7:0]  level;
    } bank_cfg_t;

    typedef struct packed {
        logic                  hit;
        logic [BANK_IDX_W-1:0] bank;
        win_ofs_e              ofs;
    } win_dec_t;

    function automatic win_dec_t decode_win(input logic [7:0] addr, input int unsigned nbanks);
        win_dec_t   d;
        logic [7:0] rel;
        rel    = addr - BANK_BASE;
        d.bank = rel[7:3];
        d.ofs  = win_ofs_e'(rel[2:0]);
        d.hit  = (addr >= BANK_BASE) && (32'(rel[7:3]) < nbanks);
        return d;
    endfunction

    function automatic pin_fn_e pin_fn(input logic [15:0] sel, input int idx);
        return pin_fn_e'(sel[2*idx +: 2]);
    endfunction

endpackage

// File: rtl/pmx_cfg_regs.sv
module pmx_cfg_regs
    import pmx_pkg::*;
#(
    parameter int NBANKS = BANKS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [7:0]              addr,
    input  logic [7:0]              wdata,
    input  logic                    we,
    output bank_cfg_t [NBANKS-1:0]  cfg
);

    win_dec_t                 dec;
    bank_cfg_t [NBANKS-1:0]   cfg_q;

    always_comb dec = decode_win(addr, NBANKS);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we && dec.hit) begin
            unique case (dec.ofs)
                OFS_SEL_LO: cfg_q[dec.bank].sel[7:0]  <= wdata;
                OFS_SEL_HI: cfg_q[dec.bank].sel[15:8] <= wdata;
                OFS_DRIVE:  cfg_q[dec.bank].drive     <= wdata;
                OFS_LEVEL:  cfg_q[dec.bank].level     <= wdata;
                default:    ;
            endcase
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/pmx_sync.sv
module pmx_sync #(
    parameter int WIDTH = 144
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= din;
            stable_q <= meta_q;
        end
    end

    assign dout = stable_q;

endmodule

// File: rtl/pmx_pad_route.sv
module pmx_pad_route
    import pmx_pkg::*;
#(
    parameter int NBANKS = BANKS,
    localparam int NPINS = NBANKS * PINS_PER_BANK
) (
    input  bank_cfg_t [NBANKS-1:0] cfg,
    input  logic [NPINS-1:0]       a_out,
    input  logic [NPINS-1:0]       a_oe,
    input  logic [NPINS-1:0]       b_out,
    input  logic [NPINS-1:0]       b_oe,
    input  logic [NPINS-1:0]       c_out,
    input  logic [NPINS-1:0]       c_oe,
    output logic [NPINS-1:0]       pad_out,
    output logic [NPINS-1:0]       pad_oe
);

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        for (genvar i = 0; i < PINS_PER_BANK; i++) begin : g_pin
            localparam int P = b * PINS_PER_BANK + i;
            pin_fn_e fn;
            assign fn = pin_fn(cfg[b].sel, i);
            always_comb begin
                unique case (fn)
                    FN_GPIO: begin
                        pad_out[P] = cfg[b].level[i];
                        pad_oe[P]  = cfg[b].drive[i];
                    end
                    FN_CLI_A: begin
                        pad_out[P] = a_out[P];
                        pad_oe[P]  = a_oe[P];
                    end
                    FN_CLI_B: begin
                        pad_out[P] = b_out[P];
                        pad_oe[P]  = b_oe[P];
                    end
                    default: begin
                        pad_out[P] = c_out[P];
                        pad_oe[P]  = c_oe[P];
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pmx_readback.sv
module pmx_readback
    import pmx_pkg::*;
#(
    parameter int NBANKS = BANKS,
    parameter bit RD_REG = 1'b1,
    localparam int NPINS = NBANKS * PINS_PER_BANK
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [7:0]             addr,
    input  bank_cfg_t [NBANKS-1:0] cfg,
    input  logic [NPINS-1:0]       sense,
    output logic [7:0]             rdata
);

    win_dec_t   dec;
    logic [7:0] rd_mux;

    always_comb begin
        dec    = decode_win(addr, NBANKS);
        rd_mux = '0;
        if (dec.hit) begin
            unique case (dec.ofs)
                OFS_SEL_LO: rd_mux = cfg[dec.bank].sel[7:0];
                OFS_SEL_HI: rd_mux = cfg[dec.bank].sel[15:8];
                OFS_DRIVE:  rd_mux = cfg[dec.bank].drive;
                OFS_LEVEL:  rd_mux = cfg[dec.bank].level;
                OFS_SENSE:  rd_mux = sense[{dec.bank, 3'b000} +: 8];
                default:    rd_mux = '0;
            endcase
        end
    end

    if (RD_REG) begin : g_reg
        logic [7:0] rdata_q;
        always_ff @(posedge clk) begin
            if (rst) rdata_q <= '0;
            else     rdata_q <= rd_mux;
        end
        assign rdata = rdata_q;
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst;
        assign rdata = rd_mux;
    end

endmodule

// File: rtl/pinmux_bank_ctrl.sv
module pinmux_bank_ctrl
    import pmx_pkg::*;
#(
    parameter int NBANKS = BANKS,
    parameter bit RD_REG = 1'b1,
    localparam int NPINS = NBANKS * PINS_PER_BANK
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             reg_we,
    output logic [7:0]       reg_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    input  logic [NPINS-1:0] cli_a_out,
    input  logic [NPINS-1:0] cli_a_oe,
    output logic [NPINS-1:0] cli_a_in,
    input  logic [NPINS-1:0] cli_b_out,
    input  logic [NPINS-1:0] cli_b_oe,
    output logic [NPINS-1:0] cli_b_in,
    input  logic [NPINS-1:0] cli_c_out,
    input  logic [NPINS-1:0] cli_c_oe,
    output logic [NPINS-1:0] cli_c_in
);

    bank_cfg_t [NBANKS-1:0] cfg;
    logic [NPINS-1:0]       sense;

    pmx_cfg_regs #(.NBANKS(NBANKS)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .we    (reg_we),
        .cfg   (cfg)
    );

    pmx_sync #(.WIDTH(NPINS)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (pad_in),
        .dout (sense)
    );

    pmx_pad_route #(.NBANKS(NBANKS)) route_i (
        .cfg     (cfg),
        .a_out   (cli_a_out),
        .a_oe    (cli_a_oe),
        .b_out   (cli_b_out),
        .b_oe    (cli_b_oe),
        .c_out   (cli_c_out),
        .c_oe    (cli_c_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    pmx_readback #(.NBANKS(NBANKS), .RD_REG(RD_REG)) rdbk_i (
        .clk   (clk),
        .rst   (rst),
        .addr  (reg_addr),
        .cfg   (cfg),
        .sense (sense),
        .rdata (reg_rdata)
    );

    // R11: raw pad levels fan out to every client
    assign cli_a_in = pad_in;
    assign cli_b_in = pad_in;
    assign cli_c_in = pad_in;

endmodule

// File: rtl/pinmux_bank_ctrl_chk.sv
module pinmux_bank_ctrl_chk
    import pmx_pkg::*;
#(
    parameter int NBANKS = BANKS,
    parameter bit RD_REG = 1'b1,
    localparam int NPINS = NBANKS * PINS_PER_BANK
) (
    input logic                   clk,
    input logic                   rst,
    input logic [7:0]             reg_addr,
    input logic                   reg_we,
    input logic [7:0]             reg_rdata,
    input logic [NPINS-1:0]       pad_in,
    input logic [NPINS-1:0]       pad_out,
    input logic [NPINS-1:0]       pad_oe,
    input bank_cfg_t [NBANKS-1:0] cfg,
    input logic [NPINS-1:0]       sense
);

    logic [1:0] cyc_q;
    always_ff @(posedge clk) begin
        if (rst)               cyc_q <= '0;
        else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
    end

    win_dec_t dec;
    logic     unmapped;
    always_comb begin
        dec      = decode_win(reg_addr, NBANKS);
        unmapped = !dec.hit || (dec.ofs == OFS_RSV4) || (dec.ofs == OFS_RSV5) || (dec.ofs == OFS_RSV7);
    end

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0));

    // R7
    sense_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_q >= 2'd2) |-> (sense == $past(pad_in, 2)));

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> $stable(cfg));

    if (RD_REG) begin : g_rr
        // R8
        unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
            $past(unmapped) |-> (reg_rdata == 8'h00));
    end else begin : g_rc
        // R8
        unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
            unmapped |-> (reg_rdata == 8'h00));
    end

endmodule

bind pinmux_bank_ctrl pinmux_bank_ctrl_chk #(.NBANKS(NBANKS), .RD_REG(RD_REG)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_rdata (reg_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .cfg       (cfg),
    .sense     (sense)
);

// File: tb/pinmux_bank_ctrl_tb_top.sv
module pinmux_bank_ctrl_tb_top;

    localparam int NP = 144;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic [NP-1:0] cli_a_out = '0, cli_a_oe = '0, cli_a_in;
    logic [NP-1:0] cli_b_out = '0, cli_b_oe = '0, cli_b_in;
    logic [NP-1:0] cli_c_out = '0, cli_c_oe = '0, cli_c_in;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pinmux_bank_ctrl dut_i (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .cli_a_out(cli_a_out), .cli_a_oe(cli_a_oe), .cli_a_in(cli_a_in),
        .cli_b_out(cli_b_out), .cli_b_oe(cli_b_oe), .cli_b_in(cli_b_in),
        .cli_c_out(cli_c_out), .cli_c_oe(cli_c_oe), .cli_c_in(cli_c_in)
    );

    // {address, write data, expected read-back}
    localparam logic [23:0] TBL [9] = '{
        {8'h20, 8'hE4, 8'hE4},   // R2 bank 0 selects, pins 0-3
        {8'h21, 8'h1B, 8'h1B},   // R2 bank 0 selects, pins 4-7
        {8'hA8, 8'h39, 8'h39},   // R1 last bank (17) selects low
        {8'hA9, 8'hC6, 8'hC6},   // R1 last bank selects high
        {8'h4A, 8'h5A, 8'h5A},   // R5 bank 5 driver byte
        {8'h4B, 8'hA5, 8'hA5},   // R6 bank 5 level byte
        {8'h4C, 8'hFF, 8'h00},   // R8 offset +4
        {8'h4F, 8'hFF, 8'h00},   // R8 offset +7
        {8'h4E, 8'hFF, 8'h00}    // R7 sense byte ignores write, pads low
    };

    task automatic check(input string req, input logic [143:0] got, input logic [143:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        check("R9 pad_oe after reset", pad_oe, '0);
        check("R9 pad_out after reset", pad_out, '0);
        rd(8'h20, v); check("R9 select byte after reset", {136'd0, v}, {136'd0, 8'h00});
        rd(8'hAA, v); check("R9 driver byte after reset", {136'd0, v}, {136'd0, 8'h00});

        // Table walk: R1 R2 R5 R6 R7 R8
        for (int k = 0; k < 9; k++) begin
            wr(TBL[k][23:16], TBL[k][15:8]);
            rd(TBL[k][23:16], v);
            check($sformatf("R1/R2/R5/R6/R7/R8 table row %0d", k), {136'd0, v}, {136'd0, TBL[k][7:0]});
        end

        // R10 registered read latency
        @(negedge clk); reg_addr = 8'h20;
        @(negedge clk); reg_addr = 8'h21;
        #1 check("R10 rdata holds previous address", {136'd0, reg_rdata}, {136'd0, 8'hE4});
        @(negedge clk);
        check("R10 rdata one cycle later", {136'd0, reg_rdata}, {136'd0, 8'h1B});

        // R3 GPIO routing, bank 2 (pins 16-23)
        cli_a_out = '1; cli_a_oe = '1;
        cli_b_out = '0; cli_b_oe = '1;
        cli_c_out = '1; cli_c_oe = '0;
        wr(8'h32, 8'h0F);
        wr(8'h33, 8'h05);
        check("R3 GPIO pad_oe from driver byte", {136'd0, pad_oe[23:16]}, {136'd0, 8'h0F});
        check("R3 GPIO pad_out from level byte", {136'd0, pad_out[23:16]}, {136'd0, 8'h05});

        // R4 mixed functions: pin20 GPIO, 21 A, 22 B, 23 C
        wr(8'h31, 8'b11_10_01_00);
        check("R4 mixed pad_out", {140'd0, pad_out[23:20]}, {140'd0, 4'b1010});
        check("R4 mixed pad_oe", {140'd0, pad_oe[23:20]}, {140'd0, 4'b0110});
        wr(8'h32, 8'hFF);
        wr(8'h33, 8'hFF);
        check("R4 client pins ignore level byte", {140'd0, pad_out[23:20]}, {140'd0, 4'b1011});
        check("R4 client pins ignore driver byte", {140'd0, pad_oe[23:20]}, {140'd0, 4'b0111});

        // R7 sense through synchroniser
        @(negedge clk);
        pad_in[7:0] = 8'hFF;
        check("R11 client A sees pad_in", cli_a_in, pad_in);
        check("R11 client C sees pad_in", cli_c_in, pad_in);
        rd(8'h26, v); check("R7 sense not yet through sync", {136'd0, v}, {136'd0, 8'h00});
        @(negedge clk);
        pad_in[143:136] = 8'hC3;
        pad_in[23:16]   = 8'h81;
        repeat (3) @(negedge clk);
        rd(8'h26, v); check("R7 sense bank 0", {136'd0, v}, {136'd0, 8'hFF});
        rd(8'hAE, v); check("R7 sense last bank", {136'd0, v}, {136'd0, 8'hC3});
        rd(8'h36, v); check("R7 sense with client functions", {136'd0, v}, {136'd0, 8'h81});
        wr(8'hAE, 8'h00);
        rd(8'hAE, v); check("R7 sense write ignored", {136'd0, v}, {136'd0, 8'hC3});
        check("R11 client B sees pad_in", cli_b_in, pad_in);

        // R8 out of range accesses
        wr(8'h1F, 8'hFF);
        wr(8'hB0, 8'hFF);
        wr(8'hB2, 8'hFF);
        rd(8'h1F, v); check("R8 below window reads zero", {136'd0, v}, {136'd0, 8'h00});
        rd(8'hB0, v); check("R8 past last bank reads zero", {136'd0, v}, {136'd0, 8'h00});
        rd(8'h22, v); check("R8 no alias into bank 0 driver", {136'd0, v}, {136'd0, 8'h00});
        rd(8'h20, v); check("R8 bank 0 select untouched", {136'd0, v}, {136'd0, 8'hE4});
        wr(8'h4D, 8'hFF);
        rd(8'h48, v); check("R8 offset +5 write no effect on select", {136'd0, v}, {136'd0, 8'h00});
        rd(8'h4A, v); check("R8 driver kept after reserved writes", {136'd0, v}, {136'd0, 8'h5A});

        finish_run();
    end

endmodule